// File: doc/BRIEF.md
# Strobe-Clocked Write Capture with Local-Domain Handoff

This block takes register writes from an external bus that has no usable bus clock. The bus write strobe serves as the clock for a small capture stage. On a strobe edge the address is decoded. If the select qualifier is also true, the address and data are held in a strobe-clocked register and a single toggle bit changes state. The toggle carries the event into the local clock domain. There it passes through a synchronizer chain, and a final flop with an XOR turns each change of level into one local-cycle pulse. On that pulse the held address and data are copied into a local register, and downstream logic sees a one-cycle valid flag.

The bus is throttled with a wait output. It goes high as soon as a qualified write has been captured. It stays high until the local domain has taken the write, which is seen as the local consume toggle matching the bus toggle again. A bus that honours wait can therefore run against a local clock that is only slightly faster than its write rate. If a qualified strobe still arrives while wait is high, it is refused and a sticky overrun flag is raised.

Top module: `async_write_capture`

## Requirements
- R1: After both resets, loc_valid is 0, loc_addr and loc_data are 0, and bus_wait and overrun are 0.
- R2: A write is qualified when bus_sel is 1 and bus_addr lies in the window 0x40 to 0x4F (default base 0x40, mask 0xF0). Each qualified write taken while bus_wait is low produces exactly one loc_valid pulse carrying the address and data present at that strobe edge.
- R3: A strobe with bus_sel at 0, or with an address outside the window, is ignored. It gives no loc_valid and leaves bus_wait low.
- R4: loc_valid is never high for two local cycles in a row.
- R5: bus_wait is high right after a qualified strobe edge. It falls again within SYNC_STAGES+2 local clock cycles (4 by default).
- R6: loc_addr and loc_data keep their value on every local cycle without loc_valid.
- R7: A qualified strobe while bus_wait is high is not delivered, sets overrun, and overrun then stays set until the bus-side reset.
- R8: Successive qualified writes are delivered in the order they were strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Local clock |
| lrst | input | 1 | Local-domain synchronous reset, active high |
| stb_clk | input | 1 | Bus write strobe, used as the capture clock |
| stb_rst | input | 1 | Bus-side reset, synchronous to strobe edges, active high |
| bus_addr | input | 8 | Write address, valid at the strobe edge |
| bus_data | input | 16 | Write data, valid at the strobe edge |
| bus_sel | input | 1 | Write qualifier from the bus |
| bus_wait | output | 1 | Stall request to the bus while a write is in flight |
| overrun | output | 1 | Sticky flag: a qualified write arrived while waiting |
| loc_valid | output | 1 | One-cycle new-write flag in the local domain |
| loc_addr | output | 8 | Delivered write address |
| loc_data | output | 16 | Delivered write data |

## Verification
The assertions assume a bus that holds off further strobes while bus_wait is high. The single exception is a deliberate overrun case, and that strobe does not change the toggle. They also assume the bus-side reset is applied with at least one strobe edge, so that the toggle and capture register start at zero. The stimulus waits for bus_wait to drop and one more local cycle before every regular write. It fires the one early strobe only while a write is known to be pending. Strobe edges are placed off the local clock edges, so each write crosses the domains as a clean level change.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

    parameter int unsigned WC_ADDR_W = 8;
    parameter int unsigned WC_DATA_W = 16;

    typedef struct packed {
        logic [WC_ADDR_W-1:0] addr;
        logic [WC_DATA_W-1:0] data;
    } wc_item_t;

    localparam int unsigned WC_ITEM_W = $bits(wc_item_t);

    function automatic logic wc_addr_hit(
        input logic [WC_ADDR_W-1:0] addr,
        input logic [WC_ADDR_W-1:0] base,
        input logic [WC_ADDR_W-1:0] mask
    );
        return ((addr ^ base) & mask) == '0;
    endfunction

endpackage

// File: rtl/wcap_sync_chain.sv
module wcap_sync_chain #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar gi;
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[gi] <= 1'b0;
                    else     chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/wcap_bus_side.sv
module wcap_bus_side
    import wcap_pkg::*;
#(
    parameter logic [WC_ADDR_W-1:0] BASE_ADDR = 8'h40,
    parameter logic [WC_ADDR_W-1:0] ADDR_MASK = 8'hF0
) (
    input  logic                 stb_clk,
    input  logic                 stb_rst,
    input  logic [WC_ADDR_W-1:0] bus_addr,
    input  logic [WC_DATA_W-1:0] bus_data,
    input  logic                 bus_sel,
    input  logic                 consumed_tog,
    output wc_item_t             held_item,
    output logic                 send_tog,
    output logic                 overrun
);
    logic qualified;
    logic in_flight;

    assign qualified = bus_sel && wc_addr_hit(bus_addr, BASE_ADDR, ADDR_MASK);
    // A write is in flight while the local side has not yet matched the toggle.
    assign in_flight = send_tog ^ consumed_tog;

    always_ff @(posedge stb_clk) begin
        if (stb_rst) begin
            held_item <= '0;
            send_tog  <= 1'b0;
            overrun   <= 1'b0;
        end else if (qualified) begin
            if (in_flight) begin
                overrun <= 1'b1;
            end else begin
                held_item.addr <= bus_addr;
                held_item.data <= bus_data;
                send_tog       <= ~send_tog;
            end
        end
    end
endmodule

// File: rtl/wcap_local_side.sv
module wcap_local_side
    import wcap_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     lclk,
    input  logic     lrst,
    input  logic     send_tog,
    input  wc_item_t held_item,
    output logic     consumed_tog,
    output logic     loc_valid,
    output wc_item_t loc_item
);
    logic tog_sync;
    logic take;

    wcap_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (lclk),
        .rst     (lrst),
        .d_async (send_tog),
        .q_sync  (tog_sync)
    );

    assign take = tog_sync ^ consumed_tog;

    always_ff @(posedge lclk) begin
        if (lrst) begin
            consumed_tog <= 1'b0;
            loc_valid    <= 1'b0;
            loc_item     <= '0;
        end else begin
            consumed_tog <= tog_sync;
            loc_valid    <= take;
            if (take) loc_item <= held_item;
        end
    end
endmodule

// File: rtl/async_write_capture.sv
module async_write_capture
    import wcap_pkg::*;
#(
    parameter logic [WC_ADDR_W-1:0] BASE_ADDR   = 8'h40,
    parameter logic [WC_ADDR_W-1:0] ADDR_MASK   = 8'hF0,
    parameter int unsigned          SYNC_STAGES = 2
) (
    input  logic                 lclk,
    input  logic                 lrst,
    input  logic                 stb_clk,
    input  logic                 stb_rst,
    input  logic [WC_ADDR_W-1:0] bus_addr,
    input  logic [WC_DATA_W-1:0] bus_data,
    input  logic                 bus_sel,
    output logic                 bus_wait,
    output logic                 overrun,
    output logic                 loc_valid,
    output logic [WC_ADDR_W-1:0] loc_addr,
    output logic [WC_DATA_W-1:0] loc_data
);
    wc_item_t held_item;
    wc_item_t loc_item;
    logic     send_tog;
    logic     consumed_tog;

    wcap_bus_side #(.BASE_ADDR(BASE_ADDR), .ADDR_MASK(ADDR_MASK)) u_bus (
        .stb_clk      (stb_clk),
        .stb_rst      (stb_rst),
        .bus_addr     (bus_addr),
        .bus_data     (bus_data),
        .bus_sel      (bus_sel),
        .consumed_tog (consumed_tog),
        .held_item    (held_item),
        .send_tog     (send_tog),
        .overrun      (overrun)
    );

    wcap_local_side #(.SYNC_STAGES(SYNC_STAGES)) u_loc (
        .lclk         (lclk),
        .lrst         (lrst),
        .send_tog     (send_tog),
        .held_item    (held_item),
        .consumed_tog (consumed_tog),
        .loc_valid    (loc_valid),
        .loc_item     (loc_item)
    );

    // Stall is a level across domains: it clears once the local copy is taken.
    assign bus_wait = send_tog ^ consumed_tog;
    assign loc_addr = loc_item.addr;
    assign loc_data = loc_item.data;
endmodule

// File: rtl/async_write_capture_chk.sv
module async_write_capture_chk
    import wcap_pkg::*;
#(
    parameter logic [WC_ADDR_W-1:0] BASE_ADDR   = 8'h40,
    parameter logic [WC_ADDR_W-1:0] ADDR_MASK   = 8'hF0,
    parameter int unsigned          SYNC_STAGES = 2
) (
    input logic                 lclk,
    input logic                 lrst,
    input logic                 stb_clk,
    input logic                 stb_rst,
    input logic                 bus_wait,
    input logic                 overrun,
    input logic                 loc_valid,
    input logic [WC_ADDR_W-1:0] loc_addr,
    input logic [WC_DATA_W-1:0] loc_data
);
    localparam int unsigned WAIT_LIMIT = SYNC_STAGES + 2;
    localparam int unsigned CNT_W      = $clog2(WAIT_LIMIT + 2) + 1;

    logic             armed;
    logic [CNT_W-1:0] wait_cnt;

    always_ff @(posedge lclk) begin
        if (lrst) begin
            armed    <= 1'b1;
            wait_cnt <= '0;
        end else if (bus_wait) begin
            if (wait_cnt <= CNT_W'(WAIT_LIMIT)) wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge lclk)
        lrst |=> (!loc_valid && loc_addr == '0 && loc_data == '0));

    a_r4_single_pulse: assert property (@(posedge lclk) disable iff (lrst)
        loc_valid |=> !loc_valid);

    a_r6_hold: assert property (@(posedge lclk) disable iff (lrst || !armed)
        !loc_valid |-> $stable({loc_addr, loc_data}));

    a_r2_addr_window: assert property (@(posedge lclk) disable iff (lrst)
        loc_valid |-> wc_addr_hit(loc_addr, BASE_ADDR, ADDR_MASK));

    a_r5_wait_bound: assert property (@(posedge lclk) disable iff (lrst)
        wait_cnt <= CNT_W'(WAIT_LIMIT));

    a_r7_overrun_sticky: assert property (@(posedge stb_clk) disable iff (stb_rst)
        overrun |=> overrun);
endmodule

bind async_write_capture async_write_capture_chk #(
    .BASE_ADDR   (BASE_ADDR),
    .ADDR_MASK   (ADDR_MASK),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .lclk      (lclk),
    .lrst      (lrst),
    .stb_clk   (stb_clk),
    .stb_rst   (stb_rst),
    .bus_wait  (bus_wait),
    .overrun   (overrun),
    .loc_valid (loc_valid),
    .loc_addr  (loc_addr),
    .loc_data  (loc_data)
);

// File: tb/async_write_capture_test.sv
`timescale 1ns/1ps
module async_write_capture_test;
    logic        lclk = 1'b0;
    logic        lrst = 1'b1;
    logic        stb_clk = 1'b0;
    logic        stb_rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wait, overrun, loc_valid;
    logic [7:0]  loc_addr;
    logic [15:0] loc_data;

    int total = 0;
    int bad = 0;
    int unexpected = 0;
    logic [23:0] expq[$];
    logic        done = 1'b0;

    always #4 lclk = ~lclk;

    async_write_capture uut (
        .lclk(lclk), .lrst(lrst), .stb_clk(stb_clk), .stb_rst(stb_rst),
        .bus_addr(bus_addr), .bus_data(bus_data), .bus_sel(bus_sel),
        .bus_wait(bus_wait), .overrun(overrun), .loc_valid(loc_valid),
        .loc_addr(loc_addr), .loc_data(loc_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic in_window(input logic [7:0] a);
        return a >= 8'h40 && a <= 8'h4F;
    endfunction

    task automatic strobe_edge();
        #3 stb_clk = 1'b1;
        #1;
    endtask

    task automatic strobe_end();
        #10 stb_clk = 1'b0;
        #3;
    endtask

    // Driver: honours bus_wait, predicts delivery, pushes the expectation.
    task automatic do_write(input logic [7:0] a, input logic [15:0] d, input logic sel);
        int n;
        while (bus_wait) @(negedge lclk);
        @(negedge lclk);
        bus_addr = a; bus_data = d; bus_sel = sel;
        if (sel && in_window(a)) expq.push_back({a, d});
        strobe_edge();
        if (sel && in_window(a)) begin
            check("R5 wait high after capture", 32'(bus_wait), 32'd1);
            n = 0;
            while (bus_wait && n < 20) begin @(posedge lclk); #1; n++; end
            total++;
            if (n < 1 || n > 4) begin
                bad++;
                $display("FAIL R5 wait release cycles actual=%0d expected=1..4", n);
            end
        end else begin
            check("R3 wait stays low on ignored strobe", 32'(bus_wait), 32'd0);
        end
        strobe_end();
        bus_sel = 1'b0;
    endtask

    // Monitor: pop on every local valid pulse, compare, and check pulse width.
    always @(negedge lclk) begin
        if (!lrst && loc_valid) begin
            if (expq.size() == 0) begin
                unexpected++;
                total++; bad++;
                $display("FAIL R3 unexpected delivery actual=%0h expected=none", {loc_addr, loc_data});
            end else begin
                check("R2 R8 delivered item", 32'({loc_addr, loc_data}), 32'(expq.pop_front()));
            end
            @(negedge lclk);
            check("R4 single-cycle valid", 32'(loc_valid), 32'd0);
        end
    end

    task automatic settle();
        repeat (10) @(negedge lclk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge lclk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] last_d;
        // resets: the bus side needs a strobe edge while its reset is high
        repeat (3) @(negedge lclk);
        strobe_edge(); strobe_end();
        stb_rst = 1'b0;
        @(negedge lclk);
        lrst = 1'b0;
        @(negedge lclk);
        check("R1 valid after reset", 32'(loc_valid), 32'd0);
        check("R1 addr after reset", 32'(loc_addr), 32'd0);
        check("R1 data after reset", 32'(loc_data), 32'd0);
        check("R1 wait after reset", 32'(bus_wait), 32'd0);
        check("R1 overrun after reset", 32'(overrun), 32'd0);

        // R2: plain deliveries at window edges
        do_write(8'h40, 16'h1234, 1'b1);
        do_write(8'h4F, 16'hBEEF, 1'b1);
        settle();
        check("R2 queue drained", 32'(expq.size()), 32'd0);

        // R6: output holds across idle cycles
        last_d = loc_data;
        repeat (15) @(negedge lclk);
        check("R6 data held", 32'(loc_data), 32'(last_d));
        check("R6 addr held", 32'(loc_addr), 32'h4F);

        // R3: sel low, address below and above window
        do_write(8'h45, 16'h0A0A, 1'b0);
        do_write(8'h3F, 16'h0B0B, 1'b1);
        do_write(8'h50, 16'h0C0C, 1'b1);
        settle();
        check("R3 no delivery for ignored writes", 32'(unexpected), 32'd0);
        check("R3 R6 data unchanged after ignored", 32'(loc_data), 32'hBEEF);

        // R8: ordered burst
        for (int i = 0; i < 8; i++) do_write(8'h40 + 8'(i), 16'hA000 + 16'(i * 17), 1'b1);
        settle();
        check("R8 burst drained", 32'(expq.size()), 32'd0);

        // R7: early strobe while a write is pending
        @(negedge lclk);
        bus_addr = 8'h42; bus_data = 16'h5555; bus_sel = 1'b1;
        expq.push_back({8'h42, 16'h5555});
        strobe_edge();
        stb_clk = 1'b0;
        bus_addr = 8'h43; bus_data = 16'h6666;
        #1 stb_clk = 1'b1;
        #1;
        check("R7 overrun set", 32'(overrun), 32'd1);
        strobe_end();
        bus_sel = 1'b0;
        settle();
        check("R7 only first delivered", 32'(loc_data), 32'h5555);
        check("R7 queue drained", 32'(expq.size()), 32'd0);
        do_write(8'h44, 16'h7777, 1'b1);
        settle();
        check("R7 overrun sticky", 32'(overrun), 32'd1);
        check("R8 delivery after overrun", 32'(loc_data), 32'h7777);

        // R7: bus-side reset clears overrun
        stb_rst = 1'b1;
        strobe_edge(); strobe_end();
        stb_rst = 1'b0;
        check("R7 overrun cleared", 32'(overrun), 32'd0);
        check("R1 wait low after bus reset", 32'(bus_wait), 32'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule